// File: doc/BRIEF.md
# Link Receive Packet Integrity Checker

This block sits between the physical-layer deframer and the transaction layer of one link. Framed packets arrive one 32-bit word per accepted beat, with start and end markers. The first word carries a 12-bit sequence number in its low bits. The last word carries a 32-bit link CRC. Every word in between is packet body. The block recomputes the CRC over the sequence word and the body, and compares the sequence number with a receive counter it maintains.

Packets that arrive in order are streamed on to the transaction layer with their sequence and CRC words removed. Forwarding starts before the CRC is known, so a packet whose CRC later fails is marked bad on its last forwarded word. Packets that arrive out of order are not forwarded.

Every packet that ends produces exactly one acknowledge or negative-acknowledge request for the transmit side. The request carries a sequence number. The decoder is one state machine per link, and one instance of the block serves one link.

Top module: `dllRxIntegrity`

## Requirements
- R1: After reset, outValid and ackValid are low and the receive counter is 0, so the first packet accepted in order carries sequence number 0.
- R2: The CRC uses polynomial 0x04C11DB7 and a register preset to all ones. Each word is fed most significant bit first, starting with the whole sequence word and followed by the body words. The result is inverted and compared with the final word of the packet.
- R3: For a packet whose sequence number equals the counter and which has at least one body word, every body word appears on outData in order and nothing else does. The first body word has outSop set and the last has outEop set. Each body word appears in the cycle after the input beat that follows it.
- R4: A good in-order packet requests an acknowledge (ackNak=0) carrying its own sequence number, and the counter increments modulo 4096, so 4095 is followed by 0.
- R5: On a CRC mismatch in a forwarded packet, outBad is set on the outEop word. A negative acknowledge (ackNak=1) is requested carrying the counter minus one, and the counter does not advance.
- R6: A sequence number ahead of the counter, meaning (seq - counter) mod 4096 lies in 1..2047, forwards nothing and requests a negative acknowledge carrying the counter minus one.
- R7: A duplicate, meaning (seq - counter) mod 4096 lies in 2048..4095, with a good CRC forwards nothing. It requests an acknowledge carrying the counter minus one and leaves the counter unchanged.
- R8: A packet of one or two beats, which has no body, forwards nothing and requests a negative acknowledge carrying the counter minus one.
- R9: Each packet end produces exactly one request, in the cycle after its end beat is accepted. Idle cycles with inValid low between the beats of a packet do not change any result.
- R10: Valid beats that arrive while no packet is open and that lack inSop produce no output and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input beat valid |
| inSop | input | 1 | Beat is the first word of a packet |
| inEop | input | 1 | Beat is the last (CRC) word of a packet |
| inData | input | 32 | Input word |
| outValid | output | 1 | Forwarded body word valid |
| outSop | output | 1 | First forwarded word of a packet |
| outEop | output | 1 | Last forwarded word of a packet |
| outBad | output | 1 | Packet failed its CRC; only with outEop |
| outData | output | 32 | Forwarded body word |
| ackValid | output | 1 | Acknowledge request strobe |
| ackNak | output | 1 | 1 = negative acknowledge, 0 = acknowledge |
| ackSeq | output | 12 | Sequence number carried by the request |

## Verification
The hardest situation to reach is the wrap of the receive counter from 4095 to 0. The modular ahead/duplicate boundary sits right at that wrap. The stimulus therefore streams short good packets back to back until the counter wraps. It then sends a duplicate of 4095, a packet exactly 2047 ahead and one exactly 2048 away. Around this sequence, seeded random packets mix corrupted CRCs, ahead and duplicate numbers, bodyless packets and idle gaps. Every forwarded word and request is compared with a bench model.

// File: rtl/dllRxPkg.sv
package dllRxPkg;

  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [WORD_W-1:0] CRC_SEED = '1;

  typedef enum logic [1:0] {
    CLS_GOOD  = 2'd0,
    CLS_AHEAD = 2'd1,
    CLS_DUP   = 2'd2
  } seqClass_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_DROP = 2'd2
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic crcInit;
    logic crcUpdate;
    logic holdLoad;
    logic emit;
    logic emitSop;
    logic emitEop;
    logic emitBad;
  } dpCtrl_t;

  // one word through the CRC register, msb first
  function automatic logic [WORD_W-1:0] crcStep(input logic [WORD_W-1:0] crcIn,
                                                input logic [WORD_W-1:0] word);
    logic [WORD_W-1:0] c;
    logic fb;
    c = crcIn;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[WORD_W-1] ^ word[i];
      c = {c[WORD_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/dllRxDatapath.sv
module dllRxDatapath
  import dllRxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inData,
  input  dpCtrl_t           ctrl,
  output logic              crcMatch,
  output logic              outValid,
  output logic              outSop,
  output logic              outEop,
  output logic              outBad,
  output logic [WORD_W-1:0] outData
);

  logic [WORD_W-1:0] crcReg;
  logic [WORD_W-1:0] holdReg;

  // final word compared with inverted running remainder
  assign crcMatch = (~crcReg == inData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg <= CRC_SEED;
    end else if (ctrl.crcInit) begin
      crcReg <= crcStep(CRC_SEED, inData);
    end else if (ctrl.crcUpdate) begin
      crcReg <= crcStep(crcReg, inData);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (ctrl.holdLoad) begin
      holdReg <= inData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSop   <= 1'b0;
      outEop   <= 1'b0;
      outBad   <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= ctrl.emit;
      outSop   <= ctrl.emit & ctrl.emitSop;
      outEop   <= ctrl.emit & ctrl.emitEop;
      outBad   <= ctrl.emit & ctrl.emitEop & ctrl.emitBad;
      if (ctrl.emit) outData <= holdReg;
    end
  end

endmodule

// File: rtl/dllRxControl.sv
module dllRxControl
  import dllRxPkg::*;
#(
  parameter int SEQ_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSop,
  input  logic             inEop,
  input  logic [SEQ_W-1:0] seqField,
  input  logic             crcMatch,
  output dpCtrl_t          ctrl,
  output logic             ackValid,
  output logic             ackNak,
  output logic [SEQ_W-1:0] ackSeq
);

  localparam logic [SEQ_W-1:0] HALF_SPAN = SEQ_W'(1) << (SEQ_W - 1);
  localparam logic [SEQ_W-1:0] SEQ_ONE   = SEQ_W'(1);

  rxState_e          state;
  seqClass_e         pktClass;
  seqClass_e         sopClass;
  logic [1:0]        beatCnt;   // 1 after seq word, saturates at 3
  logic [SEQ_W-1:0]  pktSeq;
  logic [SEQ_W-1:0]  expSeq;
  logic [SEQ_W-1:0]  seqDiff;
  logic [SEQ_W-1:0]  lastGood;
  logic              startBeat;
  logic              contBeat;
  logic              hasBody;
  logic              pktOk;

  assign seqDiff   = seqField - expSeq;
  assign lastGood  = expSeq - SEQ_ONE;
  assign startBeat = inValid & inSop;
  assign contBeat  = inValid & ~inSop & (state != ST_IDLE);
  assign hasBody   = (beatCnt >= 2'd2);
  assign pktOk     = crcMatch & hasBody;

  always_comb begin
    if (seqDiff == '0)            sopClass = CLS_GOOD;
    else if (seqDiff < HALF_SPAN) sopClass = CLS_AHEAD;
    else                          sopClass = CLS_DUP;
  end

  always_comb begin
    ctrl = '0;
    if (startBeat) begin
      ctrl.crcInit = 1'b1;
    end else if (contBeat) begin
      if (!inEop) begin
        ctrl.crcUpdate = 1'b1;
        if (state == ST_FWD) begin
          ctrl.holdLoad = 1'b1;
          ctrl.emit     = hasBody;
          ctrl.emitSop  = (beatCnt == 2'd2);
        end
      end else if (state == ST_FWD && hasBody) begin
        ctrl.emit    = 1'b1;
        ctrl.emitSop = (beatCnt == 2'd2);
        ctrl.emitEop = 1'b1;
        ctrl.emitBad = ~crcMatch;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pktClass <= CLS_GOOD;
      beatCnt  <= 2'd0;
      pktSeq   <= '0;
      expSeq   <= '0;
      ackValid <= 1'b0;
      ackNak   <= 1'b0;
      ackSeq   <= '0;
    end else begin
      ackValid <= 1'b0;
      if (startBeat) begin
        pktSeq   <= seqField;
        pktClass <= sopClass;
        beatCnt  <= 2'd1;
        if (inEop) begin
          state    <= ST_IDLE;
          ackValid <= 1'b1;
          ackNak   <= 1'b1;
          ackSeq   <= lastGood;
        end else begin
          state <= (sopClass == CLS_GOOD) ? ST_FWD : ST_DROP;
        end
      end else if (contBeat) begin
        if (beatCnt != 2'd3) beatCnt <= beatCnt + 2'd1;
        if (inEop) begin
          state    <= ST_IDLE;
          ackValid <= 1'b1;
          if (!pktOk || pktClass == CLS_AHEAD) begin
            ackNak <= 1'b1;
            ackSeq <= lastGood;
          end else if (pktClass == CLS_GOOD) begin
            ackNak <= 1'b0;
            ackSeq <= pktSeq;
            expSeq <= expSeq + SEQ_ONE;
          end else begin
            ackNak <= 1'b0;
            ackSeq <= lastGood;
          end
        end
      end
    end
  end

endmodule

// File: rtl/dllRxIntegrity.sv
module dllRxIntegrity
  import dllRxPkg::*;
#(
  parameter int SEQ_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inEop,
  input  logic [WORD_W-1:0] inData,
  output logic              outValid,
  output logic              outSop,
  output logic              outEop,
  output logic              outBad,
  output logic [WORD_W-1:0] outData,
  output logic              ackValid,
  output logic              ackNak,
  output logic [SEQ_W-1:0]  ackSeq
);

  dpCtrl_t dpCtrl;
  logic    crcMatch;

  dllRxControl #(.SEQ_W(SEQ_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inSop    (inSop),
    .inEop    (inEop),
    .seqField (inData[SEQ_W-1:0]),
    .crcMatch (crcMatch),
    .ctrl     (dpCtrl),
    .ackValid (ackValid),
    .ackNak   (ackNak),
    .ackSeq   (ackSeq)
  );

  dllRxDatapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .inData   (inData),
    .ctrl     (dpCtrl),
    .crcMatch (crcMatch),
    .outValid (outValid),
    .outSop   (outSop),
    .outEop   (outEop),
    .outBad   (outBad),
    .outData  (outData)
  );

endmodule

// File: rtl/dllRxIntegrityChk.sv
module dllRxIntegrityChk (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inEop,
  input logic outValid,
  input logic outSop,
  input logic outEop,
  input logic outBad,
  input logic ackValid,
  input logic ackNak
);

  // R9
  ack_after_eop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(inValid && inEop));

  // R5
  eop_ack_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outEop) |-> (ackValid && (ackNak == outBad)));

  // R5
  bad_only_at_eop_chk: assert property (@(posedge clk) disable iff (!rstN)
    outBad |-> (outValid && outEop));

  // R3
  quiet_markers_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(outSop || outEop || outBad));

  // R3
  out_follows_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

endmodule

bind dllRxIntegrity dllRxIntegrityChk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inEop    (inEop),
  .outValid (outValid),
  .outSop   (outSop),
  .outEop   (outEop),
  .outBad   (outBad),
  .ackValid (ackValid),
  .ackNak   (ackNak)
);

// File: tb/tb_dllRxIntegrity.sv
module tb_dllRxIntegrity;

  localparam logic [31:0] POLY = 32'h04C11DB7;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid, inSop, inEop;
  logic [31:0] inData;
  logic        outValid, outSop, outEop, outBad;
  logic [31:0] outData;
  logic        ackValid, ackNak;
  logic [11:0] ackSeq;

  always #2 clk = ~clk;

  dllRxIntegrity dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inData(inData), .outValid(outValid), .outSop(outSop), .outEop(outEop),
    .outBad(outBad), .outData(outData), .ackValid(ackValid), .ackNak(ackNak),
    .ackSeq(ackSeq)
  );

  int          checks = 0;
  int          errors = 0;
  longint      cyc = 0;
  logic [11:0] expSeq = 12'd0;
  int          outSeen = 0;
  int          ackSeen = 0;

  logic [34:0] expOutQ[$];
  string       outTagQ[$];
  logic [12:0] expAckQ[$];
  longint      expAckCycQ[$];
  string       ackTagQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] refCrc(input logic [31:0] w[$]);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    foreach (w[i]) begin
      for (int b = 3; b >= 0; b--) begin
        c = c ^ {w[i][b*8 +: 8], 24'h0};
        for (int k = 0; k < 8; k++) c = c[31] ? ((c << 1) ^ POLY) : (c << 1);
      end
    end
    return ~c;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        outSeen++;
        if (expOutQ.size() == 0) chk("R3", "unexpected out word", 1, 0);
        else chk(outTagQ.pop_front(), "out word",
                 {29'd0, outSop, outEop, outBad, outData}, {29'd0, expOutQ.pop_front()});
      end
      if (ackValid) begin
        ackSeen++;
        if (expAckQ.size() == 0) chk("R9", "unexpected request", 1, 0);
        else begin
          string t;
          t = ackTagQ.pop_front();
          chk(t, "request nak/seq", {51'd0, ackNak, ackSeq}, {51'd0, expAckQ.pop_front()});
          chk("R9", "request cycle", cyc, expAckCycQ.pop_front());
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; inSop = 1'b0; inEop = 1'b0; inData = $urandom();
    end
  endtask

  task automatic pushAck(input logic nak, input logic [11:0] s, input string tag);
    expAckQ.push_back({nak, s});
    ackTagQ.push_back(tag);
  endtask

  task automatic sendPkt(input logic [11:0] seq, input int bodyLen, input bit corrupt,
                         input int gapPct, input string tag);
    logic [31:0] w[$];
    logic [31:0] r, crcv;
    logic [11:0] d, lastGood;
    r = $urandom();
    w.push_back({r[31:12], seq});
    for (int i = 0; i < bodyLen; i++) w.push_back($urandom());
    crcv = refCrc(w);
    if (corrupt) crcv = crcv ^ (32'h1 << ($urandom() % 32));
    d = seq - expSeq;
    lastGood = expSeq - 12'd1;
    if (d == 12'd0 && bodyLen >= 1) begin
      for (int i = 0; i < bodyLen; i++) begin
        expOutQ.push_back({i == 0, i == bodyLen - 1, (i == bodyLen - 1) && corrupt, w[i+1]});
        outTagQ.push_back(corrupt ? "R5" : tag);
      end
    end
    if (corrupt || bodyLen == 0 || (d != 12'd0 && d < 12'd2048)) pushAck(1'b1, lastGood, tag);
    else if (d == 12'd0) begin
      pushAck(1'b0, seq, tag);
      expSeq = expSeq + 12'd1;
    end else pushAck(1'b0, lastGood, tag);
    w.push_back(crcv);
    for (int i = 0; i < w.size(); i++) begin
      while (($urandom() % 100) < gapPct) idle(1);
      @(negedge clk);
      inValid = 1'b1; inSop = (i == 0); inEop = (i == w.size() - 1); inData = w[i];
      if (i == w.size() - 1) expAckCycQ.push_back(cyc + 1);
    end
  endtask

  task automatic sendOneBeat(input logic [11:0] seq);
    pushAck(1'b1, expSeq - 12'd1, "R8");
    @(negedge clk);
    inValid = 1'b1; inSop = 1'b1; inEop = 1'b1; inData = {20'd0, seq};
    expAckCycQ.push_back(cyc + 1);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finishRun();
  end

  initial begin
    int o0, a0;
    void'($urandom(32'h5EED_1234));
    rstN = 1'b0; inValid = 1'b0; inSop = 1'b0; inEop = 1'b0; inData = '0;
    repeat (4) @(negedge clk);
    chk("R1", "outValid in reset", outValid, 0);
    chk("R1", "ackValid in reset", ackValid, 0);
    rstN = 1'b1;
    idle(2);
    chk("R1", "outValid after reset", outValid, 0);
    chk("R1", "ackValid after reset", ackValid, 0);

    // first packet at seq 0
    sendPkt(12'd0, 3, 0, 0, "R1");
    sendPkt(expSeq, 6, 0, 0, "R2");
    sendPkt(expSeq, 1, 0, 0, "R3");
    sendPkt(expSeq, 4, 1, 0, "R5");
    sendPkt(expSeq + 12'd5, 3, 0, 0, "R6");
    sendPkt(expSeq - 12'd3, 2, 0, 0, "R7");
    sendPkt(expSeq, 0, 0, 0, "R8");
    sendOneBeat(expSeq);
    sendPkt(expSeq, 5, 0, 60, "R9");
    idle(4);

    // stray beats with no open packet
    o0 = outSeen; a0 = ackSeen;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      inValid = 1'b1; inSop = 1'b0; inEop = (i == 2); inData = {20'd0, expSeq};
    end
    idle(4);
    chk("R10", "out words from stray beats", outSeen - o0, 0);
    chk("R10", "requests from stray beats", ackSeen - a0, 0);
    sendPkt(expSeq, 2, 0, 0, "R10");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int p, len;
      logic [11:0] s;
      p = $urandom() % 100;
      len = ($urandom() % 10 == 0) ? 0 : 1 + ($urandom() % 6);
      if (p < 65) s = expSeq;
      else if (p < 82) s = expSeq + 12'(1 + $urandom() % 2047);
      else s = expSeq - 12'(1 + $urandom() % 2048);
      sendPkt(s, len, ($urandom() % 100) < 15, 20, "R3");
    end

    // drive the counter through its wrap
    do sendPkt(expSeq, 1, 0, 0, "R4"); while (expSeq != 12'd0);
    sendPkt(12'd4095, 1, 0, 0, "R7");
    sendPkt(expSeq + 12'd2047, 1, 0, 0, "R6");
    sendPkt(expSeq + 12'd2048, 1, 0, 0, "R7");
    sendPkt(expSeq, 2, 0, 0, "R4");
    idle(8);

    chk("R9", "pending requests", expAckQ.size(), 0);
    chk("R3", "pending out words", expOutQ.size(), 0);
    finishRun();
  end

endmodule